// File: doc/BRIEF.md
# Memory-Mapped Network Byte Port

This block is a small network interface that a processor reaches as three device registers in its own address space. Software sends a byte by storing it in the outgoing data register and then setting a busy flag in the status register. The hardware offers the byte to an abstract link with a valid/ready handshake and clears the flag once the link has taken it. Bytes from the link are latched into an incoming data register and flagged as valid until software loads them.

The registers sit at addresses 96, 97 and 98, inside the range kept for privileged code. An access made with the privilege input low has no effect, so user code has to go through the operating system to reach the device. Two level interrupt outputs, each with its own enable bit, let software wait for events instead of polling: one for an idle transmitter and one for a waiting received byte. Line framing, the physical layer and block transfers are outside this block.

Top module: `mbp_port`

## Requirements
- R1: After reset, the status register (address 98) reads 0x00, tx_valid is low and both interrupt outputs are low.
- R2: A privileged store to address 96 while status bit 0 is clear loads the outgoing byte, which reads back at 96 and drives tx_byte. A store to 96 while bit 0 is set is ignored.
- R3: A privileged store to 98 with bit 0 equal to 1 sets the busy bit (bit 0) while the port is idle. tx_valid is high exactly while the busy bit is set, and tx_byte is held stable over that time.
- R4: The busy bit clears in the cycle after a clock edge at which tx_valid and tx_ready are both high. One set of the busy bit sends one byte only.
- R5: A byte offered with rx_valid high is stored in the incoming register (load at 97), and status bit 1 becomes 1 after that edge.
- R6: A privileged load from 97 clears status bit 1 at that edge, unless a new byte arrives in the same cycle.
- R7: A byte that arrives while bit 1 is set, and is not consumed in the same cycle, replaces the stored byte and sets the overrun bit (bit 2). A privileged store to 98 with bit 2 equal to 1 clears the overrun bit.
- R8: Status bit 4 enables irq_tx_done and bit 5 enables irq_rx_avail; both bits are written by a store to 98. irq_tx_done is high while bit 4 is set and bit 0 is clear. irq_rx_avail is high while bits 5 and 1 are both set.
- R9: With bus_kernel low, stores have no effect, loads return 0, and a load from 97 leaves bit 1 unchanged.
- R10: Loads from any address other than 96, 97 and 98 return 0, and stores to such addresses change no register.
- R11: When a byte arrives in the same cycle as a privileged load from 97, the load returns the old byte. The new byte is kept, bit 1 stays set, and no overrun is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Load/store address |
| bus_wr | input | 1 | Store strobe |
| bus_rd | input | 1 | Load strobe |
| bus_kernel | input | 1 | Access made in privileged mode |
| bus_wdata | input | 8 | Store data |
| bus_rdata | output | 8 | Load data (combinational) |
| tx_byte | output | 8 | Byte offered to the link |
| tx_valid | output | 1 | Offered byte is valid |
| tx_ready | input | 1 | Link accepts the byte |
| rx_byte | input | 8 | Byte from the link |
| rx_valid | input | 1 | Link delivers a byte this cycle |
| irq_tx_done | output | 1 | Transmitter idle interrupt |
| irq_rx_avail | output | 1 | Received byte interrupt |

## Verification
The bench writes the outgoing register while the port is busy. A design that ignored the busy bit would change tx_byte during a handshake. It holds tx_ready high after a completion, which a design that resent the byte would expose. It delivers two bytes without a load in between, so a missing overrun bit or a stale stored byte shows up. It lines up an arrival with a load in the same cycle; a design that let the load win there would drop a byte. Unprivileged stores and loads, including a load from the incoming register, are checked through the status register. A design that leaked user accesses would show changed enable bits or a lost valid bit.

// File: rtl/mbp_pkg.sv
`timescale 1ns/1ps
package mbp_pkg;

    // Bit positions inside the status register.
    localparam int ST_BUSY = 0;
    localparam int ST_RXV  = 1;
    localparam int ST_OVR  = 2;
    localparam int ST_IETX = 4;
    localparam int ST_IERX = 5;
    localparam int ST_BITS = 8;

    // Decoded access strobes for one bus cycle.
    typedef struct packed {
        logic wr_tx;
        logic wr_stat;
        logic rd_rx;
        logic sel_tx;
        logic sel_rx;
        logic sel_stat;
    } mbp_sel_t;

    // Architectural status, kept as a struct.
    typedef struct packed {
        logic busy;
        logic rx_full;
        logic ovr;
        logic ie_tx;
        logic ie_rx;
    } mbp_state_t;

    function automatic logic [ST_BITS-1:0] pack_status(input mbp_state_t s);
        logic [ST_BITS-1:0] v;
        v          = '0;
        v[ST_BUSY] = s.busy;
        v[ST_RXV]  = s.rx_full;
        v[ST_OVR]  = s.ovr;
        v[ST_IETX] = s.ie_tx;
        v[ST_IERX] = s.ie_rx;
        return v;
    endfunction

endpackage

// File: rtl/mbp_decode.sv
`timescale 1ns/1ps
module mbp_decode
    import mbp_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int BASE_ADDR    = 96,
    parameter bit ENFORCE_PRIV = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic              kernel,
    output mbp_sel_t          sel
);
    localparam logic [ADDR_W-1:0] A_TX   = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] A_RX   = ADDR_W'(BASE_ADDR + 1);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(BASE_ADDR + 2);

    logic allowed;

    generate
        if (ENFORCE_PRIV) begin : g_priv
            assign allowed = kernel;
        end else begin : g_open
            logic unused_kernel;
            assign unused_kernel = kernel;
            assign allowed = 1'b1;
        end
    endgenerate

    always_comb begin
        sel          = '0;
        sel.wr_tx    = allowed && wr && (addr == A_TX);
        sel.wr_stat  = allowed && wr && (addr == A_STAT);
        sel.rd_rx    = allowed && rd && (addr == A_RX);
        sel.sel_tx   = allowed && rd && (addr == A_TX);
        sel.sel_rx   = sel.rd_rx;
        sel.sel_stat = allowed && rd && (addr == A_STAT);
    end
endmodule

// File: rtl/mbp_tx.sv
`timescale 1ns/1ps
module mbp_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              start,
    input  logic              link_ready,
    output logic              busy,
    output logic [DATA_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            data <= '0;
        end else begin
            if (load && !busy)
                data <= load_data;
            if (busy && link_ready)
                busy <= 1'b0;
            else if (!busy && start)
                busy <= 1'b1;
        end
    end
endmodule

// File: rtl/mbp_rx.sv
`timescale 1ns/1ps
module mbp_rx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_byte,
    input  logic              take,
    input  logic              ovr_clr,
    output logic [DATA_W-1:0] data,
    output logic              full,
    output logic              ovr
);
    logic ovr_set;
    assign ovr_set = in_valid && full && !take;

    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
            full <= 1'b0;
            ovr  <= 1'b0;
        end else begin
            if (in_valid) begin
                data <= in_byte;
                full <= 1'b1;
            end else if (take) begin
                full <= 1'b0;
            end
            if (ovr_set)
                ovr <= 1'b1;
            else if (ovr_clr)
                ovr <= 1'b0;
        end
    end
endmodule

// File: rtl/mbp_port.sv
`timescale 1ns/1ps
module mbp_port
    import mbp_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 8,
    parameter int BASE_ADDR    = 96,
    parameter bit ENFORCE_PRIV = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_kernel,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] tx_byte,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_valid,
    output logic              irq_tx_done,
    output logic              irq_rx_avail
);
    localparam int STAT_PAD = DATA_W - ST_BITS;

    mbp_sel_t          sel;
    mbp_state_t        st;
    logic              busy;
    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;
    logic              rx_full;
    logic              ovr;
    logic              ie_tx;
    logic              ie_rx;
    logic [ST_BITS-1:0] stat_word;

    mbp_decode #(
        .ADDR_W       (ADDR_W),
        .BASE_ADDR    (BASE_ADDR),
        .ENFORCE_PRIV (ENFORCE_PRIV)
    ) u_dec (
        .addr   (bus_addr),
        .wr     (bus_wr),
        .rd     (bus_rd),
        .kernel (bus_kernel),
        .sel    (sel)
    );

    mbp_tx #(.DATA_W(DATA_W)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .load       (sel.wr_tx),
        .load_data  (bus_wdata),
        .start      (sel.wr_stat && bus_wdata[ST_BUSY]),
        .link_ready (tx_ready),
        .busy       (busy),
        .data       (tx_q)
    );

    mbp_rx #(.DATA_W(DATA_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .in_valid (rx_valid),
        .in_byte  (rx_byte),
        .take     (sel.rd_rx),
        .ovr_clr  (sel.wr_stat && bus_wdata[ST_OVR]),
        .data     (rx_q),
        .full     (rx_full),
        .ovr      (ovr)
    );

    // Interrupt enable bits, written whole on every status store.
    always_ff @(posedge clk) begin
        if (rst) begin
            ie_tx <= 1'b0;
            ie_rx <= 1'b0;
        end else if (sel.wr_stat) begin
            ie_tx <= bus_wdata[ST_IETX];
            ie_rx <= bus_wdata[ST_IERX];
        end
    end

    always_comb begin
        st         = '0;
        st.busy    = busy;
        st.rx_full = rx_full;
        st.ovr     = ovr;
        st.ie_tx   = ie_tx;
        st.ie_rx   = ie_rx;
    end

    assign stat_word = pack_status(st);

    generate
        if (STAT_PAD > 0) begin : g_pad
            always_comb begin
                bus_rdata = '0;
                if (sel.sel_tx)   bus_rdata = tx_q;
                if (sel.sel_rx)   bus_rdata = rx_q;
                if (sel.sel_stat) bus_rdata = {{STAT_PAD{1'b0}}, stat_word};
            end
        end else begin : g_nopad
            always_comb begin
                bus_rdata = '0;
                if (sel.sel_tx)   bus_rdata = tx_q;
                if (sel.sel_rx)   bus_rdata = rx_q;
                if (sel.sel_stat) bus_rdata = stat_word;
            end
        end
    endgenerate

    assign tx_byte      = tx_q;
    assign tx_valid     = busy;
    assign irq_tx_done  = ie_tx && !busy;
    assign irq_rx_avail = ie_rx && rx_full;
endmodule

// File: rtl/mbp_checker.sv
`timescale 1ns/1ps
module mbp_checker #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int BASE_ADDR = 96
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              bus_kernel,
    input logic [DATA_W-1:0] tx_byte,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [DATA_W-1:0] rx_byte,
    input logic              rx_valid,
    input logic              irq_tx_done,
    input logic              irq_rx_avail,
    input logic [DATA_W-1:0] rx_q,
    input logic              rx_full,
    input logic              ovr
);
    localparam logic [ADDR_W-1:0] A_RX = ADDR_W'(BASE_ADDR + 1);

    logic rx_take;
    assign rx_take = bus_rd && bus_kernel && (bus_addr == A_RX);

    assert_hold_byte_R2: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

    assert_one_shot_R4: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !tx_valid);

    assert_capture_R5: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> (rx_full && rx_q == $past(rx_byte)));

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_take && !rx_valid) |=> !rx_full);

    assert_overrun_R7: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_full && !rx_take) |=> ovr);

    assert_irq_tx_R8: assert property (@(posedge clk) disable iff (rst)
        irq_tx_done |-> !tx_valid);

    assert_irq_rx_R8: assert property (@(posedge clk) disable iff (rst)
        irq_rx_avail |-> rx_full);

    assert_user_store_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_kernel) |=> $stable(tx_byte));

    assert_same_cycle_R11: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_take) |=> (rx_full && !$rose(ovr)));
endmodule

bind mbp_port mbp_checker #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .BASE_ADDR (BASE_ADDR)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_kernel   (bus_kernel),
    .tx_byte      (tx_byte),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .rx_byte      (rx_byte),
    .rx_valid     (rx_valid),
    .irq_tx_done  (irq_tx_done),
    .irq_rx_avail (irq_rx_avail),
    .rx_q         (rx_q),
    .rx_full      (rx_full),
    .ovr          (ovr)
);

// File: tb/mbp_port_tb.sv
`timescale 1ns/1ps
module mbp_port_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_kernel = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] tx_byte;
    logic       tx_valid;
    logic       tx_ready = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_valid = 1'b0;
    logic       irq_tx_done;
    logic       irq_rx_avail;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mbp_port u_dut (
        .clk          (clk),
        .rst          (rst),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_kernel   (bus_kernel),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .tx_byte      (tx_byte),
        .tx_valid     (tx_valid),
        .tx_ready     (tx_ready),
        .rx_byte      (rx_byte),
        .rx_valid     (rx_valid),
        .irq_tx_done  (irq_tx_done),
        .irq_rx_avail (irq_rx_avail)
    );

    // Bus vector: store/load/privilege/address/data/check flag/expected/tag.
    typedef struct packed {
        logic       wr;
        logic       rd;
        logic       kern;
        logic [7:0] addr;
        logic [7:0] wd;
        logic       chk;
        logic [7:0] exp;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 1'b1, 8'd98, 8'h00, 1'b1, 8'h00, 8'd1},   // R1 status after reset
        '{1'b1, 1'b0, 1'b1, 8'd96, 8'hA5, 1'b0, 8'h00, 8'd2},
        '{1'b0, 1'b1, 1'b1, 8'd96, 8'h00, 1'b1, 8'hA5, 8'd2},   // R2 readback
        '{1'b1, 1'b0, 1'b1, 8'd98, 8'h01, 1'b0, 8'h00, 8'd3},
        '{1'b0, 1'b1, 1'b1, 8'd98, 8'h00, 1'b1, 8'h01, 8'd3},   // R3 busy set
        '{1'b1, 1'b0, 1'b1, 8'd96, 8'h3C, 1'b0, 8'h00, 8'd2},
        '{1'b0, 1'b1, 1'b1, 8'd96, 8'h00, 1'b1, 8'hA5, 8'd2},   // R2 store while busy ignored
        '{1'b1, 1'b0, 1'b0, 8'd98, 8'h30, 1'b0, 8'h00, 8'd9},
        '{1'b0, 1'b1, 1'b0, 8'd98, 8'h00, 1'b1, 8'h00, 8'd9},   // R9 user load returns 0
        '{1'b0, 1'b1, 1'b1, 8'd98, 8'h00, 1'b1, 8'h01, 8'd9},   // R9 user store had no effect
        '{1'b1, 1'b0, 1'b1, 8'd99, 8'h30, 1'b0, 8'h00, 8'd10},
        '{1'b0, 1'b1, 1'b1, 8'd98, 8'h00, 1'b1, 8'h01, 8'd10},  // R10 stray store no effect
        '{1'b0, 1'b1, 1'b1, 8'd99, 8'h00, 1'b1, 8'h00, 8'd10},  // R10 stray load returns 0
        '{1'b1, 1'b0, 1'b1, 8'd98, 8'h31, 1'b0, 8'h00, 8'd8},
        '{1'b0, 1'b1, 1'b1, 8'd98, 8'h00, 1'b1, 8'h31, 8'd8}    // R8 enables stored
    };

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // One bus/link cycle: drive after the falling edge, settle, then the rising edge commits.
    task automatic cyc(input logic wr, input logic rd, input logic kern,
                       input logic [7:0] a, input logic [7:0] wd,
                       input logic rdy, input logic rxv, input logic [7:0] rxb);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_kernel = kern;
        bus_addr = a; bus_wdata = wd;
        tx_ready = rdy; rx_valid = rxv; rx_byte = rxb;
        #1;
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, 1'b0, 8'd0, 8'h00, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic load(input logic [7:0] a);
        cyc(1'b0, 1'b1, 1'b1, a, 8'h00, 1'b0, 1'b0, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            cyc(VECS[i].wr, VECS[i].rd, VECS[i].kern, VECS[i].addr, VECS[i].wd,
                1'b0, 1'b0, 8'h00);
            if (VECS[i].chk)
                check8($sformatf("R%0d vector %0d", VECS[i].req, i), bus_rdata, VECS[i].exp);
        end

        // R3: byte offered while busy, R8: no idle interrupt yet
        idle();
        check8("R3 tx_valid", {7'd0, tx_valid}, 8'h01);
        check8("R3 tx_byte", tx_byte, 8'hA5);
        check8("R8 irq_tx while busy", {7'd0, irq_tx_done}, 8'h00);

        // R4: handshake, then ready held on to prove a single send
        cyc(1'b0, 1'b0, 1'b0, 8'd0, 8'h00, 1'b1, 1'b0, 8'h00);
        cyc(1'b0, 1'b0, 1'b0, 8'd0, 8'h00, 1'b1, 1'b0, 8'h00);
        check8("R4 busy cleared", {7'd0, tx_valid}, 8'h00);
        check8("R8 irq_tx when idle", {7'd0, irq_tx_done}, 8'h01);
        load(8'd98);
        check8("R4 status after send", bus_rdata, 8'h30);
        idle();
        check8("R4 no resend", {7'd0, tx_valid}, 8'h00);

        // R5 / R6: receive, read, clear
        cyc(1'b0, 1'b0, 1'b0, 8'd0, 8'h00, 1'b0, 1'b1, 8'h5A);
        load(8'd97);
        check8("R5 rx data", bus_rdata, 8'h5A);
        check8("R8 irq_rx", {7'd0, irq_rx_avail}, 8'h01);
        load(8'd98);
        check8("R6 valid cleared", bus_rdata, 8'h30);
        check8("R6 irq_rx low", {7'd0, irq_rx_avail}, 8'h00);

        // R7: overrun
        cyc(1'b0, 1'b0, 1'b0, 8'd0, 8'h00, 1'b0, 1'b1, 8'h11);
        cyc(1'b0, 1'b0, 1'b0, 8'd0, 8'h00, 1'b0, 1'b1, 8'h22);
        load(8'd98);
        check8("R7 overrun status", bus_rdata, 8'h36);
        load(8'd97);
        check8("R7 newest byte kept", bus_rdata, 8'h22);
        cyc(1'b1, 1'b0, 1'b1, 8'd98, 8'h34, 1'b0, 1'b0, 8'h00);
        load(8'd98);
        check8("R7 overrun cleared", bus_rdata, 8'h30);

        // R9: user load from receive register neither reads nor consumes
        cyc(1'b0, 1'b0, 1'b0, 8'd0, 8'h00, 1'b0, 1'b1, 8'h44);
        cyc(1'b0, 1'b1, 1'b0, 8'd97, 8'h00, 1'b0, 1'b0, 8'h00);
        check8("R9 user rx load", bus_rdata, 8'h00);
        load(8'd98);
        check8("R9 valid kept", bus_rdata, 8'h32);

        // R11: arrival in the same cycle as a load
        cyc(1'b0, 1'b1, 1'b1, 8'd97, 8'h00, 1'b0, 1'b1, 8'h55);
        check8("R11 old byte returned", bus_rdata, 8'h44);
        load(8'd98);
        check8("R11 valid kept no overrun", bus_rdata, 8'h32);
        load(8'd97);
        check8("R11 new byte kept", bus_rdata, 8'h55);

        // R1: reset mid-run
        cyc(1'b0, 1'b0, 1'b0, 8'd0, 8'h00, 1'b0, 1'b1, 8'h66);
        @(negedge clk); rst = 1'b1; rx_valid = 1'b0;
        @(negedge clk);
        @(negedge clk); rst = 1'b0;
        load(8'd98);
        check8("R1 status after reset", bus_rdata, 8'h00);
        check8("R1 tx_valid after reset", {7'd0, tx_valid}, 8'h00);
        check8("R1 irqs after reset", {6'd0, irq_tx_done, irq_rx_avail}, 8'h00);
        idle();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule